// File: doc/BRIEF.md
# External Interrupt Trigger Detector

This block turns two active-low external interrupt pins into request lines for an interrupt controller. Each pin first passes through a synchroniser. A software-controlled trigger bit then selects one of two detection modes. In latched falling-edge mode, a high-to-low transition sets a sticky pending flag. In unlatched low-level mode, the request simply follows the synchronised pin.

Software reaches the block through a four-bit control nibble that holds each channel's trigger bit and pending flag. The interrupt controller tells the block when it begins servicing a channel (acknowledge) and when that service routine returns (return pulse). While a channel is in service, fresh falling edges on that channel are not captured. The return pulse clears the channel's latched flag.

Top module: `xint_detector`

## Requirements
- R1: After reset, the control nibble reads 0000 (both channels in level mode, no flags) and both request outputs are low.
- R2: The control nibble layout is: bit 0 = channel 0 trigger, bit 1 = channel 0 flag, bit 2 = channel 1 trigger, bit 3 = channel 1 flag. A written trigger bit reads back on the next cycle.
- R3: With trigger = 0 (level), a channel's request equals the inverse of its pin delayed by two clocks. The channel's flag bit reads the same live value.
- R4: With trigger = 1 (edge), a falling pin sets the channel's flag and request on the third clock edge after the pin changes.
- R5: In edge mode, a set flag stays set after the pin returns high. Neither a rising edge nor a steady low sets it again.
- R6: An acknowledge pulse puts a channel in service until its return pulse. A falling edge seen in that window does not set the flag.
- R7: In edge mode, a return pulse clears that channel's flag on the next clock edge.
- R8: In edge mode, writing the flag bit sets or clears it directly. If a hardware edge and a software clear arrive in the same cycle, the flag ends up set.
- R9: Level mode never latches. A flag written to 1, or left over from edge mode, is discarded while the channel is in level mode, and switching back to edge mode does not bring it back.
- R10: Activity on one channel never changes the other channel's request or nibble bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xpin_n | input | 2 | Asynchronous active-low interrupt pins, one per channel |
| ctl_wr | input | 1 | Write strobe for the control nibble |
| ctl_wdata | input | 4 | Control nibble write data |
| ctl_rdata | output | 4 | Control nibble read data |
| svc_ack | input | 2 | Per-channel acknowledge pulse (service starts) |
| svc_ret | input | 2 | Per-channel return-from-service pulse |
| irq_req | output | 2 | Per-channel request to the interrupt controller |

## Verification
The bench sweeps all four trigger configurations on each channel and counts the exact cycle in which the request rises. A detector with one synchroniser stage too few or too many would raise it a cycle early or late. It checks that the edge flag persists after the pin rises and that the return pulse clears it. A design that treated edge mode as level mode, or ignored the return pulse, would fail these checks. Directed cases hit a falling edge inside an acknowledged service window, which a design without masking would latch. They also hit a software clear landing in the same cycle as a hardware edge, which a design with the wrong priority would lose. A further case checks that flags do not survive a trip through level mode.

// File: rtl/xint_pkg.sv
// Package: shared types for the external interrupt detector.
// Assumes: the nibble layout places trigger at bit 2c and flag at 2c+1.
package xint_pkg;
    typedef enum logic {
        TRIG_LEVEL = 1'b0,
        TRIG_FALL  = 1'b1
    } trig_e;

    localparam int unsigned BITS_PER_CH = 2;

    // Bit position of a channel's trigger bit inside the control nibble.
    function automatic int unsigned trig_pos(input int unsigned ch);
        return ch * BITS_PER_CH;
    endfunction

    // Bit position of a channel's flag bit inside the control nibble.
    function automatic int unsigned flag_pos(input int unsigned ch);
        return ch * BITS_PER_CH + 1;
    endfunction
endpackage

// File: rtl/xint_sync.sv
// Module: multi-stage synchroniser for one asynchronous pin.
// Assumes: STAGES >= 2; every stage resets to RST_VAL (the idle pin level).
module xint_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d_async};
    end

    assign q_sync = chain_q[STAGES-1];
endmodule

// File: rtl/xint_chan.sv
// Module: one interrupt channel - trigger-mode bit, falling-edge capture,
// sticky flag, in-service window and the request output.
// Assumes: s_pin is already synchronised. The flag priority is
// hardware set > software write > return clear. Level mode holds the flag at 0.
module xint_chan
    import xint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic s_pin,
    input  logic wr,
    input  logic wr_trig,
    input  logic wr_flag,
    input  logic ack,
    input  logic ret,
    output logic trig_rd,
    output logic flag_rd,
    output logic req
);
    trig_e trig_q, trig_d;
    logic  prev_q;
    logic  flag_q, flag_d;
    logic  svc_q;
    logic  fall, capture;

    // Previous synchronised sample, for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= s_pin;
    end

    assign fall = prev_q & ~s_pin;

    // Next trigger mode: software write takes effect this cycle.
    always_comb begin
        trig_d = trig_q;
        if (wr) trig_d = trig_e'(wr_trig);
    end

    // Trigger-mode register; level mode after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) trig_q <= TRIG_LEVEL;
        else        trig_q <= trig_d;
    end

    // In-service window: opened by acknowledge, closed by return.
    always_ff @(posedge clk) begin
        if (!rst_n) svc_q <= 1'b0;
        else        svc_q <= ack | (svc_q & ~ret);
    end

    assign capture = fall & ~(svc_q | ack) & (trig_d == TRIG_FALL);

    // Next flag value under the fixed priority order.
    always_comb begin
        flag_d = flag_q;
        if (trig_d == TRIG_LEVEL) flag_d = 1'b0;
        else if (capture)         flag_d = 1'b1;
        else if (wr)              flag_d = wr_flag;
        else if (ret)             flag_d = 1'b0;
    end

    // Sticky edge flag register.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    // Request: latched flag in edge mode, live low pin in level mode.
    always_comb begin
        if (trig_q == TRIG_FALL) req = flag_q;
        else                     req = ~s_pin;
    end

    assign trig_rd = trig_q;
    assign flag_rd = req;
endmodule

// File: rtl/xint_detector.sv
// Module: top of the external interrupt detector. It synchronises each pin,
// instantiates one channel per pin and maps the channels onto the control
// nibble. Assumes: the controller pulses svc_ack/svc_ret for one cycle.
module xint_detector
    import xint_pkg::*;
#(
    parameter int unsigned NCH         = 2,
    parameter int unsigned SYNC_STAGES = 2,
    localparam int unsigned RW         = NCH * BITS_PER_CH
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [NCH-1:0] xpin_n,
    input  logic           ctl_wr,
    input  logic [RW-1:0]  ctl_wdata,
    output logic [RW-1:0]  ctl_rdata,
    input  logic [NCH-1:0] svc_ack,
    input  logic [NCH-1:0] svc_ret,
    output logic [NCH-1:0] irq_req
);
    logic [NCH-1:0] pin_s;

    // One synchroniser and one channel per pin.
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        xint_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
            .clk     (clk),
            .rst_n   (rst_n),
            .d_async (xpin_n[c]),
            .q_sync  (pin_s[c])
        );

        xint_chan u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .s_pin   (pin_s[c]),
            .wr      (ctl_wr),
            .wr_trig (ctl_wdata[trig_pos(c)]),
            .wr_flag (ctl_wdata[flag_pos(c)]),
            .ack     (svc_ack[c]),
            .ret     (svc_ret[c]),
            .trig_rd (ctl_rdata[trig_pos(c)]),
            .flag_rd (ctl_rdata[flag_pos(c)]),
            .req     (irq_req[c])
        );
    end
endmodule

// File: rtl/xint_checker.sv
// Module: property checker for xint_detector, bound to every instance.
// Tracks the in-service window itself from the acknowledge and return ports.
module xint_checker #(
    parameter int unsigned NCH = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NCH-1:0]   xpin_n,
    input logic             ctl_wr,
    input logic [2*NCH-1:0] ctl_wdata,
    input logic [2*NCH-1:0] ctl_rdata,
    input logic [NCH-1:0]   svc_ack,
    input logic [NCH-1:0]   svc_ret,
    input logic [NCH-1:0]   irq_req
);
    logic [NCH-1:0] svc_m;

    // Independent model of the in-service window.
    always_ff @(posedge clk) begin
        if (!rst_n) svc_m <= '0;
        else        svc_m <= svc_ack | (svc_m & ~svc_ret);
    end

    for (genvar c = 0; c < NCH; c++) begin : g_prop
        assert_trig_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ctl_wr |=> ctl_rdata[2*c] == $past(ctl_wdata[2*c]));

        assert_level_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !ctl_rdata[2*c] |-> irq_req[c] == !$past(xpin_n[c], 2));

        assert_edge_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (ctl_rdata[2*c] && irq_req[c] && !ctl_wr && !svc_ret[c]) |=> irq_req[c]);

        assert_svc_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (svc_m[c] && ctl_rdata[2*c] && !irq_req[c] && !ctl_wr) |=> !irq_req[c]);

        assert_ret_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (svc_m[c] && svc_ret[c] && ctl_rdata[2*c] && !ctl_wr) |=> !irq_req[c]);
    end
endmodule

bind xint_detector xint_checker #(.NCH(NCH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .xpin_n    (xpin_n),
    .ctl_wr    (ctl_wr),
    .ctl_wdata (ctl_wdata),
    .ctl_rdata (ctl_rdata),
    .svc_ack   (svc_ack),
    .svc_ret   (svc_ret),
    .irq_req   (irq_req)
);

// File: tb/sim_xint_detector.sv
module sim_xint_detector;
    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] xpin_n = 2'b11;
    logic       ctl_wr = 1'b0;
    logic [3:0] ctl_wdata = 4'h0;
    logic [3:0] ctl_rdata;
    logic [1:0] svc_ack = 2'b00;
    logic [1:0] svc_ret = 2'b00;
    logic [1:0] irq_req;

    int checks = 0;
    int errors = 0;
    logic ed, ex;
    logic [3:0] wd;

    always #(PERIOD/2) clk = ~clk;

    xint_detector u0 (
        .clk(clk), .rst_n(rst_n), .xpin_n(xpin_n), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .svc_ack(svc_ack),
        .svc_ret(svc_ret), .irq_req(irq_req)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(input logic [3:0] d);
        ctl_wr = 1'b1; ctl_wdata = d; tick(1); ctl_wr = 1'b0;
    endtask

    task automatic pulse_ack(input int c);
        svc_ack[c] = 1'b1; tick(1); svc_ack = 2'b00;
    endtask

    task automatic pulse_ret(input int c);
        svc_ret[c] = 1'b1; tick(1); svc_ret = 2'b00;
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    initial begin
        #(PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        tick(4);
        rst_n = 1'b1;
        tick(1);
        check("R1 nibble", ctl_rdata, 4'h0);
        check("R1 request", {2'b00, irq_req}, 4'h0);

        // R2: layout and readback
        do_wr(4'b0101); check("R2 readback", ctl_rdata, 4'b0101);
        do_wr(4'b1111); check("R2 flags", ctl_rdata, 4'b1111);
        check("R8 direct set", {2'b00, irq_req}, 4'h3);
        do_wr(4'b0000); check("R2 clear", ctl_rdata, 4'b0000);

        // Sweep: every trigger configuration on each channel.
        for (int cfg = 0; cfg < 4; cfg++) begin
            for (int c = 0; c < 2; c++) begin
                wd = {1'b0, cfg[1], 1'b0, cfg[0]};
                do_wr(wd);
                tick(4);
                ed = cfg[c];
                xpin_n[c] = 1'b0;
                for (int t = 1; t <= 4; t++) begin
                    tick(1);
                    ex = ed ? (t >= 3) : (t >= 2);
                    check(ed ? "R4 edge timing" : "R3 level timing", {3'b0, irq_req[c]}, {3'b0, ex});
                    check("R10 other channel", {3'b0, irq_req[1-c]}, 4'h0);
                end
                check(ed ? "R4 flag bit" : "R3 flag bit", {3'b0, ctl_rdata[2*c+1]}, 4'h1);
                xpin_n[c] = 1'b1;
                tick(3);
                check(ed ? "R5 latched" : "R9 unlatched", {3'b0, irq_req[c]}, {3'b0, ed});
                if (ed) begin
                    pulse_ret(c);
                    check("R7 return clears", {3'b0, irq_req[c]}, 4'h0);
                end
                check("R10 other bits", {2'b00, ctl_rdata[2*(1-c)+1], ctl_rdata[2*(1-c)]},
                      {2'b00, 1'b0, cfg[1-c]});
            end
        end

        // R6: edge during service is ignored
        do_wr(4'b0001);
        pulse_ack(0);
        xpin_n[0] = 1'b0; tick(4);
        check("R6 masked in service", {3'b0, irq_req[0]}, 4'h0);
        xpin_n[0] = 1'b1; tick(3);
        pulse_ret(0);
        check("R6 still clear after return", {3'b0, irq_req[0]}, 4'h0);
        xpin_n[0] = 1'b0; tick(3);
        check("R6 capture after window", {3'b0, irq_req[0]}, 4'h1);
        xpin_n[0] = 1'b1; tick(2);
        pulse_ret(0);
        check("R7 clear", {3'b0, irq_req[0]}, 4'h0);

        // R8: direct write and collision with a hardware edge
        do_wr(4'b0011); check("R8 write set", ctl_rdata, 4'b0011);
        do_wr(4'b0001); check("R8 write clear", ctl_rdata, 4'b0001);
        xpin_n[0] = 1'b0; tick(2);
        do_wr(4'b0001);
        check("R8 hw set beats sw clear", {3'b0, irq_req[0]}, 4'h1);

        // R9: flag discarded in level mode
        xpin_n[0] = 1'b1; tick(3);
        do_wr(4'b0000); check("R9 level drops flag", ctl_rdata, 4'b0000);
        do_wr(4'b0001); check("R9 flag not restored", ctl_rdata, 4'b0001);
        do_wr(4'b1010); check("R9 level write ignored", ctl_rdata, 4'b0000);
        check("R9 no request", {2'b00, irq_req}, 4'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule